// File: doc/BRIEF.md
# Sequenced Three-Tap FIR Filter

This block computes a three-tap finite impulse response over a stream of signed 24-bit samples and returns a 48-bit weighted sum. It has one multiplier and one accumulator. A controller walks them through the three taps in a fixed schedule, so the area stays small and throughput is one sample every five clocks. The coefficients are fixed when the block is built.

An upstream source presents a sample with a valid strobe while the filter is idle. The filter captures the sample and forms the three products, newest sample first. It then publishes the sum, ages the two history registers, and raises a one-cycle ready flag. The sum stays on the output until the next result replaces it. A strobe that arrives while a sample is in flight is not taken. The source must offer that sample again once the filter is idle.

Top module: `fir3_seq`

## Requirements
- R1: A synchronous reset clears the published sum to 0, the ready flag to 0 and both history samples to 0, and returns the filter to idle.
- R2: Each published sum equals COEF0·x(n) + COEF1·x(n-1) + COEF2·x(n-2). Here x(n) is the sample just accepted, and history the filter has not yet seen counts as 0. Samples, coefficients and sum are two's complement, and the sum wraps modulo 2^48 without saturating.
- R3: If `smp_vld` is sampled high at clock edge k while the filter is idle, `sum_rdy` is high for exactly one cycle, from edge k+4 to edge k+5.
- R4: `sum_out` changes only at the edge where `sum_rdy` rises, and holds its value at every other edge.
- R5: The filter ignores `smp_vld` and `smp_in` at the four edges that follow an accepted sample. Such a strobe produces no ready pulse and does not alter any later sum.
- R6: While the filter is idle and `smp_vld` is low, it stays idle and `sum_rdy` stays 0.
- R7: With `smp_vld` held high continuously, the filter accepts a new sample every five clocks. The first is taken at edge k+5 after a sample accepted at edge k, and one ready pulse follows each accepted sample.
- R8: The history registers age only when a result is published. The first result after reset is therefore COEF0·x(n) alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_in | input | 24 | Signed input sample |
| smp_vld | input | 1 | Sample strobe, taken only while idle |
| sum_out | output | 48 | Signed filter result, held between commits |
| sum_rdy | output | 1 | One-cycle pulse marking a fresh result |

## Verification
Two events can fall on the same clock edge: a new strobe being accepted, and the previous result being published. If the valid strobe is held high without a break, the edge that clears the ready flag is also the edge that loads the next sample. This happens while the delay line has only just aged. The bench holds `smp_vld` high for many cycles with a different sample value on every cycle. A behavioural queue model decides which values are taken and what each sum must be, and it is compared with both outputs at every clock.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
    localparam int NUM_TAPS  = 3;
    localparam int TAP_IDX_W = $clog2(NUM_TAPS);

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TAP0   = 3'd1,
        ST_TAP1   = 3'd2,
        ST_TAP2   = 3'd3,
        ST_COMMIT = 3'd4
    } fir3_state_e;
endpackage

// File: rtl/fir3_ctrl.sv
module fir3_ctrl
    import fir3_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_vld,
    output logic                 ld_en,
    output logic                 mac_first,
    output logic [TAP_IDX_W-1:0] tap_idx,
    output logic                 commit
);
    typedef struct packed {
        fir3_state_e st;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        ld_en     = 1'b0;
        mac_first = 1'b0;
        tap_idx   = '0;
        commit    = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (smp_vld) begin
                    ld_en  = 1'b1;
                    c_d.st = ST_TAP0;
                end
            end
            ST_TAP0: begin
                mac_first = 1'b1;
                tap_idx   = TAP_IDX_W'(0);
                c_d.st    = ST_TAP1;
            end
            ST_TAP1: begin
                tap_idx = TAP_IDX_W'(1);
                c_d.st  = ST_TAP2;
            end
            ST_TAP2: begin
                tap_idx = TAP_IDX_W'(2);
                c_d.st  = ST_COMMIT;
            end
            ST_COMMIT: begin
                commit = 1'b1;
                c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '{st: ST_IDLE};
        else     c_q <= c_d;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (c_q.st == ST_IDLE && !smp_vld) |=> (c_q.st == ST_IDLE)); // R6
    AST_TAP0_NEXT: assert property (@(posedge clk) disable iff (rst)
        (c_q.st == ST_TAP0) |=> (c_q.st == ST_TAP1)); // R5
    AST_TAP2_NEXT: assert property (@(posedge clk) disable iff (rst)
        (c_q.st == ST_TAP2) |=> (c_q.st == ST_COMMIT)); // R5
    AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (c_q.st == ST_COMMIT) |=> (c_q.st == ST_IDLE)); // R7
endmodule

// File: rtl/fir3_line.sv
module fir3_line #(
    parameter int DATA_W = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ld_en,
    input  logic                     commit,
    input  logic signed [DATA_W-1:0] smp_in,
    output logic signed [DATA_W-1:0] cur_q,
    output logic signed [DATA_W-1:0] old1_q,
    output logic signed [DATA_W-1:0] old2_q
);
    typedef struct packed {
        logic signed [DATA_W-1:0] cur;
        logic signed [DATA_W-1:0] old1;
        logic signed [DATA_W-1:0] old2;
    } line_t;

    line_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (ld_en) l_d.cur = smp_in;
        if (commit) begin
            l_d.old2 = l_q.old1;
            l_d.old1 = l_q.cur;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) l_q <= '0;
        else     l_q <= l_d;
    end

    assign cur_q  = l_q.cur;
    assign old1_q = l_q.old1;
    assign old2_q = l_q.old2;

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(old1_q) && $stable(old2_q))); // R8
endmodule

// File: rtl/fir3_mac.sv
module fir3_mac
    import fir3_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int ACC_W  = 48,
    parameter logic signed [DATA_W-1:0] COEF0 = 3,
    parameter logic signed [DATA_W-1:0] COEF1 = -2,
    parameter logic signed [DATA_W-1:0] COEF2 = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mac_first,
    input  logic [TAP_IDX_W-1:0]     tap_idx,
    input  logic                     commit,
    input  logic signed [DATA_W-1:0] cur_q,
    input  logic signed [DATA_W-1:0] old1_q,
    input  logic signed [DATA_W-1:0] old2_q,
    output logic signed [ACC_W-1:0]  sum_out,
    output logic                     sum_rdy
);
    localparam int PROD_W = 2 * DATA_W;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] res;
        logic                    rdy;
    } mac_t;

    mac_t m_d, m_q;
    logic signed [DATA_W-1:0] opnd, coef;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_x;
    logic                     run;

    always_comb begin
        case (tap_idx)
            TAP_IDX_W'(1): begin opnd = old1_q; coef = COEF1; end
            TAP_IDX_W'(2): begin opnd = old2_q; coef = COEF2; end
            default:       begin opnd = cur_q;  coef = COEF0; end
        endcase
    end

    assign prod   = opnd * coef;
    assign prod_x = ACC_W'(prod);

    // the accumulator advances on TAP0 (mac_first) and on TAP1/TAP2 (tap_idx != 0)
    assign run = mac_first || (tap_idx != '0);

    always_comb begin
        m_d     = m_q;
        m_d.rdy = commit;
        if (run) m_d.acc = mac_first ? prod_x : (m_q.acc + prod_x);
        if (commit) m_d.res = m_q.acc;
    end

    always_ff @(posedge clk) begin
        if (rst) m_q <= '0;
        else     m_q <= m_d;
    end

    assign sum_out = m_q.res;
    assign sum_rdy = m_q.rdy;

    AST_RDY_PULSE: assert property (@(posedge clk) disable iff (rst)
        sum_rdy |=> !sum_rdy); // R3
    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sum_rdy |-> $stable(sum_out)); // R4
    AST_COMMIT_RDY: assert property (@(posedge clk) disable iff (rst)
        commit |=> sum_rdy); // R3
endmodule

// File: rtl/fir3_seq.sv
module fir3_seq #(
    parameter int DATA_W = 24,
    parameter int ACC_W  = 48,
    parameter logic signed [DATA_W-1:0] COEF0 = 3,
    parameter logic signed [DATA_W-1:0] COEF1 = -2,
    parameter logic signed [DATA_W-1:0] COEF2 = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] smp_in,
    input  logic                     smp_vld,
    output logic signed [ACC_W-1:0]  sum_out,
    output logic                     sum_rdy
);
    import fir3_pkg::*;

    logic                     ld_en, mac_first, commit;
    logic [TAP_IDX_W-1:0]     tap_idx;
    logic signed [DATA_W-1:0] cur_q, old1_q, old2_q;

    fir3_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .smp_vld   (smp_vld),
        .ld_en     (ld_en),
        .mac_first (mac_first),
        .tap_idx   (tap_idx),
        .commit    (commit)
    );

    fir3_line #(.DATA_W(DATA_W)) i_line (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .commit (commit),
        .smp_in (smp_in),
        .cur_q  (cur_q),
        .old1_q (old1_q),
        .old2_q (old2_q)
    );

    fir3_mac #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W),
        .COEF0  (COEF0),
        .COEF1  (COEF1),
        .COEF2  (COEF2)
    ) i_mac (
        .clk       (clk),
        .rst       (rst),
        .mac_first (mac_first),
        .tap_idx   (tap_idx),
        .commit    (commit),
        .cur_q     (cur_q),
        .old1_q    (old1_q),
        .old2_q    (old2_q),
        .sum_out   (sum_out),
        .sum_rdy   (sum_rdy)
    );

    AST_LOAD_NOT_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !(ld_en && commit)); // R5
endmodule

// File: tb/test_fir3_seq.sv
module test_fir3_seq;
    localparam logic signed [23:0] K0 = 24'sh7FFFFF;
    localparam logic signed [23:0] K1 = 24'sh800000;
    localparam logic signed [23:0] K2 = 24'sh7FFFFF;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [23:0] smp_in = '0;
    logic               smp_vld = 1'b0;
    logic signed [47:0] sum_out;
    logic               sum_rdy;

    int n_chk = 0, n_fail = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    fir3_seq #(.COEF0(K0), .COEF1(K1), .COEF2(K2)) i_fir3_seq (
        .clk(clk), .rst(rst), .smp_in(smp_in), .smp_vld(smp_vld),
        .sum_out(sum_out), .sum_rdy(sum_rdy)
    );

    always #5 clk = ~clk;

    // behavioural reference: history queue, phase counter
    longint hist[$];
    longint pend;
    int     phase = 0;
    logic signed [47:0] exp_sum = '0;
    logic               exp_rdy = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            hist = {0, 0}; phase = 0; exp_sum = '0; exp_rdy = 1'b0;
        end else begin
            exp_rdy = 1'b0;
            if (phase == 0) begin
                if (smp_vld) begin pend = longint'(smp_in); phase = 1; end
            end else if (phase < 4) begin
                phase++;
            end else begin
                longint y;
                y = longint'(K0) * pend + longint'(K1) * hist[0] + longint'(K2) * hist[1];
                exp_sum = y[47:0];
                exp_rdy = 1'b1;
                hist.push_front(pend);
                void'(hist.pop_back());
                phase = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) if (cmp_on) begin
        chk(sum_rdy === exp_rdy, "R3 ready timing", longint'(sum_rdy), longint'(exp_rdy));
        chk(sum_out === exp_sum, exp_rdy ? "R2 sum value" : "R4 sum hold",
            longint'(sum_out), longint'(exp_sum));
    end

    int rdy_cnt = 0;
    always @(negedge clk) if (sum_rdy === 1'b1) rdy_cnt++;

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic send(input logic signed [23:0] x);
        smp_in = x; smp_vld = 1'b1;
        step(1);
        smp_vld = 1'b0;
        step(5);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        @(negedge clk);
        chk(sum_out === '0 && sum_rdy === 1'b0, "R1 reset state", longint'(sum_out), 0);
        cmp_on = 1'b1;
        step(1);

        // R8: first result after reset uses only the newest tap
        send(24'sd5);
        chk(sum_out === 48'(longint'(K0) * 5), "R8 first result", longint'(sum_out),
            longint'(K0) * 5);

        // R6: idle with strobe low
        rdy_cnt = 0;
        step(12);
        chk(rdy_cnt == 0, "R6 idle no pulse", rdy_cnt, 0);

        // R2: mixed signs, then wrap case min,max,min
        send(-24'sd7); send(24'sd1000); send(-24'sd123456);
        send(24'sh800000); send(24'sh7FFFFF); send(24'sh800000);
        chk(sum_out === exp_sum, "R2 wrap case", longint'(sum_out), longint'(exp_sum));

        // R5: strobe during calculation is ignored
        rdy_cnt = 0;
        smp_in = 24'sd42; smp_vld = 1'b1; step(1);
        smp_vld = 1'b0; step(1);
        smp_in = 24'sd999; smp_vld = 1'b1; step(1);
        smp_vld = 1'b0; step(12);
        chk(rdy_cnt == 1, "R5 one pulse only", rdy_cnt, 1);

        // R7: strobe held high, changing sample each cycle
        rdy_cnt = 0;
        smp_vld = 1'b1;
        for (int i = 0; i < 25; i++) begin
            smp_in = 24'(i * 977 - 9000);
            step(1);
        end
        smp_vld = 1'b0;
        step(8);
        chk(rdy_cnt == 5, "R7 back-to-back pulses", rdy_cnt, 5);

        // R1: reset during a calculation
        send(24'sd3);
        smp_in = 24'sd77; smp_vld = 1'b1; step(1);
        smp_vld = 1'b0; step(1);
        rst = 1'b1; step(2);
        rst = 1'b0;
        @(negedge clk);
        chk(sum_out === '0 && sum_rdy === 1'b0, "R1 mid-run reset", longint'(sum_out), 0);
        step(1);
        send(24'sd11);
        chk(sum_out === 48'(longint'(K0) * 11), "R1 history cleared", longint'(sum_out),
            longint'(K0) * 11);

        step(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule